// File: doc/BRIEF.md
# Dual-Issue In-Order Dispatch Controller

This block sits between a micro-op queue and the execution back end of a vector pipeline. Each cycle it looks at the two oldest queued micro-ops, called slot 0 (older) and slot 1 (younger). It decides which of them leave the queue. A micro-op that leaves goes to one of five execution reservation stations and is also recorded in the reorder buffer. The block is pure decision logic. Operand data and payload formatting are handled elsewhere. The block only sees the per-slot flags that summarise hazards and the ready signals of its consumers.

A slot leaves only when every party to the transfer agrees in the same cycle. The queue must offer it, the selected station must accept it and the reorder buffer must accept it. Hazards gate this:
- a read of a result still pending in the reorder buffer;
- a younger slot that reads the older slot's destination;
- a pair that needs more vector source operands than the read ports supply.

Slots never leave out of order. Each slot that leaves is given a reorder-buffer tag equal to the buffer's next free index plus the slot number.

Top module: `dispatch_issue_ctrl`

## Requirements
- R1: Slot 0 is taken (`slot_take[0]`=1) exactly when `slot_valid[0]`=1, `slot_rob_wait[0]`=0, its unit code is legal, the selected station's ready for slot 0 is 1 and `rob_ready[0]`=1.
- R2: Slot 1 is taken only when slot 0 is taken in the same cycle. With that met, it needs the same conditions as R1 applied to slot 1, plus R3 to R5.
- R3: `slot_rob_wait[1]`=1 blocks slot 1 and leaves the decision for slot 0 unchanged.
- R4: `slot_dep_prev[0]`=1 means slot 1 reads slot 0's destination. It blocks slot 1.
- R5: `src_limit_hit`=1 means the pair needs more than four vector source operands. It blocks slot 1 and leaves slot 0 free to go.
- R6: Unit codes are ALU=0, permute/reduction=1, multiply=2, divide=3, load-store=4. Codes 5 to 7 are illegal and are never taken. A taken slot raises exactly the station valid `stn_valid[code][slot]`. An untaken slot raises none.
- R7: `rob_valid[s]` equals `slot_take[s]` for every slot.
- R8: `rob_tag[s]` equals `rob_free_idx + s`, modulo 2^TAG_W.
- R9: The inputs of slot 1 (valid, unit, ROB wait, pair dependency, source limit, its readies) have no effect on the outputs of slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slot_valid | input | SLOTS | Queue offers a micro-op in the slot |
| slot_unit | input | SLOTS x 3 | Execution unit code per slot |
| slot_rob_wait | input | SLOTS | Slot reads a pending reorder-buffer result |
| slot_dep_prev | input | SLOTS-1 | Slot k+1 reads the destination of an older slot in the group |
| src_limit_hit | input | 1 | Group exceeds the vector read-port budget |
| stn_ready | input | 5 x SLOTS | Ready per station per slot |
| rob_ready | input | SLOTS | Reorder buffer ready per slot |
| rob_free_idx | input | TAG_W | Next free reorder-buffer index |
| slot_take | output | SLOTS | Ready back to the queue: slot leaves this cycle |
| stn_valid | output | 5 x SLOTS | Valid per station per slot |
| rob_valid | output | SLOTS | Valid to the reorder buffer per slot |
| rob_tag | output | SLOTS x TAG_W | Reorder-buffer tag per slot |

## Verification
The bench sweeps every pair of unit codes, including the illegal ones, against all 64 combinations of the two valid flags, two ROB-wait flags, the pair dependency and the source limit. The readies are drawn fresh for each vector. This separates an illegal code from a busy station, a slot-1 hazard from a slot-0 stall, and a correct station from a neighbouring one. Directed cases cover the idle state, tag wrap at the top of the index range, and a slot 0 held fixed while every slot-1 input toggles. The slot-1 toggle case shows that the younger slot cannot disturb the older one.

// File: rtl/dp_issue_pkg.sv
// dp_issue_pkg: shared constants and the execution-unit code for the
// dispatch controller. Assumes unit codes at or above NUM_UNITS are illegal.
package dp_issue_pkg;
    localparam int NUM_UNITS = 5;
    localparam int UNIT_W    = 3;

    typedef enum logic [UNIT_W-1:0] {
        UNIT_ALU  = 3'd0,
        UNIT_PERM = 3'd1,
        UNIT_MUL  = 3'd2,
        UNIT_DIV  = 3'd3,
        UNIT_LSU  = 3'd4
    } unit_e;
endpackage

// File: rtl/dp_hazard_gate.sv
// dp_hazard_gate: folds the hazard flags of one slot into an eligibility bit.
// Assumes the caller ties the group-level flags low for the oldest slot.
module dp_hazard_gate (
    input  logic slot_valid,
    input  logic rob_wait,
    input  logic dep_prev,
    input  logic src_limit,
    output logic eligible
);
    // A slot is eligible when it is offered and none of its hazards apply.
    always_comb begin
        eligible = slot_valid & ~rob_wait & ~dep_prev & ~src_limit;
    end
endmodule

// File: rtl/dp_unit_decode.sv
// dp_unit_decode: turns a unit code into a one-hot station select and picks
// that station's ready. An illegal code gives an all-zero select and no ready.
module dp_unit_decode
    import dp_issue_pkg::*;
(
    input  logic [UNIT_W-1:0]    unit_code,
    input  logic [NUM_UNITS-1:0] ready_in,
    output logic [NUM_UNITS-1:0] sel_onehot,
    output logic                 sel_ready
);
    genvar u;
    generate
        for (u = 0; u < NUM_UNITS; u++) begin : g_unit
            // Compare against each legal code.
            always_comb sel_onehot[u] = (unit_code == UNIT_W'(u));
        end
    endgenerate

    // The ready of the chosen station, zero when no station is chosen.
    always_comb sel_ready = |(sel_onehot & ready_in);
endmodule

// File: rtl/dp_issue_chain.sv
// dp_issue_chain: in-order issue decision. A slot is taken when it is
// eligible, its station and the reorder buffer accept it, and every older
// slot is taken in the same cycle.
module dp_issue_chain #(
    parameter int SLOTS = 2
) (
    input  logic [SLOTS-1:0] eligible,
    input  logic [SLOTS-1:0] stn_ok,
    input  logic [SLOTS-1:0] rob_ok,
    output logic [SLOTS-1:0] take
);
    genvar k;
    generate
        for (k = 0; k < SLOTS; k++) begin : g_slot
            if (k == 0) begin : g_head
                // The oldest slot depends only on its own agreement.
                always_comb take[k] = eligible[k] & stn_ok[k] & rob_ok[k];
            end else begin : g_tail
                // Younger slots also need their predecessor taken.
                always_comb take[k] = eligible[k] & stn_ok[k] & rob_ok[k] & take[k-1];
            end
        end
    endgenerate
endmodule

// File: rtl/dispatch_issue_ctrl.sv
// dispatch_issue_ctrl: decides each cycle which of the SLOTS oldest
// micro-ops leave the queue. Each micro-op that leaves raises valid to exactly
// one reservation station and to the reorder buffer, and gets a tag.
// Assumes consumers take a transfer when valid is high, because valid is
// already qualified by every ready involved.
module dispatch_issue_ctrl
    import dp_issue_pkg::*;
#(
    parameter int SLOTS = 2,
    parameter int TAG_W = 4
) (
    input  logic [SLOTS-1:0]                  slot_valid,
    input  logic [SLOTS-1:0][UNIT_W-1:0]      slot_unit,
    input  logic [SLOTS-1:0]                  slot_rob_wait,
    input  logic [SLOTS-2:0]                  slot_dep_prev,
    input  logic                              src_limit_hit,
    input  logic [NUM_UNITS-1:0][SLOTS-1:0]   stn_ready,
    input  logic [SLOTS-1:0]                  rob_ready,
    input  logic [TAG_W-1:0]                  rob_free_idx,
    output logic [SLOTS-1:0]                  slot_take,
    output logic [NUM_UNITS-1:0][SLOTS-1:0]   stn_valid,
    output logic [SLOTS-1:0]                  rob_valid,
    output logic [SLOTS-1:0][TAG_W-1:0]       rob_tag
);
    logic [SLOTS-1:0]                 eligible;
    logic [SLOTS-1:0]                 stn_ok;
    logic [SLOTS-1:0][NUM_UNITS-1:0]  ready_by_slot;
    logic [SLOTS-1:0][NUM_UNITS-1:0]  onehot;
    logic [SLOTS-1:0]                 dep_in;
    logic [SLOTS-1:0]                 lim_in;

    genvar s, u;
    generate
        for (s = 0; s < SLOTS; s++) begin : g_slot
            if (s == 0) begin : g_old
                // The oldest slot has no group-level hazards.
                always_comb begin
                    dep_in[s] = 1'b0;
                    lim_in[s] = 1'b0;
                end
            end else begin : g_young
                // Younger slots see the pair dependency and the read-port limit.
                always_comb begin
                    dep_in[s] = slot_dep_prev[s-1];
                    lim_in[s] = src_limit_hit;
                end
            end

            for (u = 0; u < NUM_UNITS; u++) begin : g_col
                // Regroup station readies per slot.
                always_comb ready_by_slot[s][u] = stn_ready[u][s];
                // Route the take to the selected station only.
                always_comb stn_valid[u][s] = onehot[s][u] & slot_take[s];
            end

            dp_hazard_gate u_gate (
                .slot_valid (slot_valid[s]),
                .rob_wait   (slot_rob_wait[s]),
                .dep_prev   (dep_in[s]),
                .src_limit  (lim_in[s]),
                .eligible   (eligible[s])
            );

            dp_unit_decode u_dec (
                .unit_code  (slot_unit[s]),
                .ready_in   (ready_by_slot[s]),
                .sel_onehot (onehot[s]),
                .sel_ready  (stn_ok[s])
            );

            // Tag is the next free index offset by slot position.
            always_comb rob_tag[s] = rob_free_idx + TAG_W'(s);
        end
    endgenerate

    dp_issue_chain #(.SLOTS(SLOTS)) u_chain (
        .eligible (eligible),
        .stn_ok   (stn_ok),
        .rob_ok   (rob_ready),
        .take     (slot_take)
    );

    // The reorder buffer sees the same transfer as the queue.
    always_comb rob_valid = slot_take;
endmodule

// File: rtl/dispatch_issue_ctrl_chk.sv
// dispatch_issue_ctrl_chk: checker for the dispatch controller, bound to
// every instance. The block has no state, so each check is an immediate
// check of the settled port values.
module dispatch_issue_ctrl_chk
    import dp_issue_pkg::*;
#(
    parameter int SLOTS = 2,
    parameter int TAG_W = 4
) (
    input logic [SLOTS-1:0]                  slot_valid,
    input logic [SLOTS-1:0]                  slot_rob_wait,
    input logic [SLOTS-2:0]                  slot_dep_prev,
    input logic                              src_limit_hit,
    input logic [SLOTS-1:0]                  rob_ready,
    input logic [SLOTS-1:0]                  slot_take,
    input logic [NUM_UNITS-1:0][SLOTS-1:0]   stn_valid,
    input logic [SLOTS-1:0]                  rob_valid
);
    genvar s;
    generate
        for (s = 0; s < SLOTS; s++) begin : g_slot
            logic [NUM_UNITS-1:0] col;
            // Gather the station valids of this slot.
            always_comb begin
                for (int u = 0; u < NUM_UNITS; u++) col[u] = stn_valid[u][s];
            end

            // Check the per-slot handshake relations.
            always_comb begin
                AST_TAKE_NEEDS_OFFER: assert (!slot_take[s] || (slot_valid[s] && rob_ready[s])); // R1
                AST_ROB_WAIT_HOLDS: assert (!(slot_rob_wait[s] && slot_take[s])); // R3
                AST_ONE_STATION: assert ($countones(col) == (slot_take[s] ? 1 : 0)); // R6
                AST_ROB_MIRRORS_QUEUE: assert (rob_valid[s] == slot_take[s]); // R7
            end

            if (s > 0) begin : g_young
                // Check ordering and the pair-level blocks.
                always_comb begin
                    AST_IN_ORDER: assert (!slot_take[s] || slot_take[s-1]); // R2
                    AST_PAIR_DEP_HOLDS: assert (!(slot_dep_prev[s-1] && slot_take[s])); // R4
                    AST_SRC_LIMIT_HOLDS: assert (!(src_limit_hit && slot_take[s])); // R5
                end
            end
        end
    endgenerate
endmodule

bind dispatch_issue_ctrl dispatch_issue_ctrl_chk #(
    .SLOTS (SLOTS),
    .TAG_W (TAG_W)
) u_chk (
    .slot_valid    (slot_valid),
    .slot_rob_wait (slot_rob_wait),
    .slot_dep_prev (slot_dep_prev),
    .src_limit_hit (src_limit_hit),
    .rob_ready     (rob_ready),
    .slot_take     (slot_take),
    .stn_valid     (stn_valid),
    .rob_valid     (rob_valid)
);

// File: tb/dispatch_issue_ctrl_tb.sv
// Self-checking bench: sweeps unit-code pairs against all hazard-flag
// combinations with drawn readies, plus directed tag and isolation cases.
module dispatch_issue_ctrl_tb;
    localparam int SLOTS = 2;
    localparam int TAG_W = 4;
    localparam int NU    = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [SLOTS-1:0]          slot_valid;
    logic [SLOTS-1:0][2:0]     slot_unit;
    logic [SLOTS-1:0]          slot_rob_wait;
    logic [SLOTS-2:0]          slot_dep_prev;
    logic                      src_limit_hit;
    logic [NU-1:0][SLOTS-1:0]  stn_ready;
    logic [SLOTS-1:0]          rob_ready;
    logic [TAG_W-1:0]          rob_free_idx;
    logic [SLOTS-1:0]          slot_take;
    logic [NU-1:0][SLOTS-1:0]  stn_valid;
    logic [SLOTS-1:0]          rob_valid;
    logic [SLOTS-1:0][TAG_W-1:0] rob_tag;

    int n_run  = 0;
    int n_fail = 0;

    dispatch_issue_ctrl #(.SLOTS(SLOTS), .TAG_W(TAG_W)) u_dut (
        .slot_valid    (slot_valid),
        .slot_unit     (slot_unit),
        .slot_rob_wait (slot_rob_wait),
        .slot_dep_prev (slot_dep_prev),
        .src_limit_hit (src_limit_hit),
        .stn_ready     (stn_ready),
        .rob_ready     (rob_ready),
        .rob_free_idx  (rob_free_idx),
        .slot_take     (slot_take),
        .stn_valid     (stn_valid),
        .rob_valid     (rob_valid),
        .rob_tag       (rob_tag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model computed from the requirements.
    logic exp_t0, exp_t1;
    logic [NU-1:0][SLOTS-1:0] exp_stn;

    task automatic model();
        exp_t0 = slot_valid[0] && !slot_rob_wait[0] && (slot_unit[0] < 3'd5)
                 && stn_ready[slot_unit[0] % 5][0] && rob_ready[0];
        exp_t1 = exp_t0 && slot_valid[1] && !slot_rob_wait[1] && !slot_dep_prev[0]
                 && !src_limit_hit && (slot_unit[1] < 3'd5)
                 && stn_ready[slot_unit[1] % 5][1] && rob_ready[1];
        exp_stn = '0;
        if (exp_t0) exp_stn[slot_unit[0]][0] = 1'b1;
        if (exp_t1) exp_stn[slot_unit[1]][1] = 1'b1;
    endtask

    task automatic check_all();
        string r1;
        model();
        if (slot_rob_wait[1])      r1 = "R3";
        else if (slot_dep_prev[0]) r1 = "R4";
        else if (src_limit_hit)    r1 = "R5";
        else                       r1 = "R2";
        check("R1", int'(slot_take[0]), int'(exp_t0));
        check(r1, int'(slot_take[1]), int'(exp_t1));
        check("R6", int'(stn_valid), int'(exp_stn));
        check("R7", int'(rob_valid), int'({exp_t1, exp_t0}));
        check("R8", int'(rob_tag[1]), int'(TAG_W'(rob_free_idx + 1)));
        check("R8", int'(rob_tag[0]), int'(rob_free_idx));
    endtask

    function automatic logic [NU*SLOTS-1:0] mostly_ones();
        return ~($urandom() & $urandom());
    endfunction

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [1:0] t0_ref;
        logic [NU-1:0] c0_ref;

        slot_valid = '0; slot_unit = '0; slot_rob_wait = '0; slot_dep_prev = '0;
        src_limit_hit = 1'b0; stn_ready = '1; rob_ready = '1; rob_free_idx = '0;
        @(negedge clk);
        // Idle: nothing offered, nothing leaves (R1, R7).
        check("R1", int'(slot_take), 0);
        check("R7", int'(rob_valid), 0);
        check("R6", int'(stn_valid), 0);

        // Sweep of unit codes against every hazard-flag combination.
        for (int u0 = 0; u0 < 8; u0++) begin
            for (int u1 = 0; u1 < 8; u1++) begin
                for (int f = 0; f < 64; f++) begin
                    @(posedge clk);
                    slot_unit[0]     = 3'(u0);
                    slot_unit[1]     = 3'(u1);
                    slot_valid       = 2'(f);
                    slot_rob_wait    = 2'(f >> 2);
                    slot_dep_prev[0] = f[4];
                    src_limit_hit    = f[5];
                    stn_ready        = mostly_ones();
                    rob_ready        = 2'(~($urandom() & $urandom()));
                    rob_free_idx     = TAG_W'($urandom());
                    @(negedge clk);
                    check_all();
                end
            end
        end

        // Tag wrap at the top of the index range (R8).
        @(posedge clk);
        rob_free_idx = '1;
        @(negedge clk);
        check("R8", int'(rob_tag[1]), 0);
        check("R8", int'(rob_tag[0]), (1 << TAG_W) - 1);

        // Slot 0 fixed and ready; slot 1 inputs toggled (R9, R3, R5).
        @(posedge clk);
        slot_valid[0] = 1'b1; slot_unit[0] = 3'd3; slot_rob_wait[0] = 1'b0;
        stn_ready = '1; rob_ready = '1;
        @(negedge clk);
        t0_ref = {1'b0, slot_take[0]};
        for (int u = 0; u < NU; u++) c0_ref[u] = stn_valid[u][0];
        check("R9", int'(t0_ref), 1);
        for (int p = 0; p < 256; p++) begin
            @(posedge clk);
            slot_valid[1]    = p[0];
            slot_rob_wait[1] = p[1];
            slot_dep_prev[0] = p[2];
            src_limit_hit    = p[3];
            slot_unit[1]     = 3'(p >> 4);
            for (int u = 0; u < NU; u++) stn_ready[u][1] = p[u % 3 + 4];
            rob_ready[1]     = p[7];
            @(negedge clk);
            begin
                logic [NU-1:0] c0;
                for (int u = 0; u < NU; u++) c0[u] = stn_valid[u][0];
                check("R9", int'(slot_take[0]), int'(t0_ref[0]));
                check("R9", int'(c0), int'(c0_ref));
            end
            check_all();
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule